// File: doc/BRIEF.md
# Glitch-Filtered Serial Command Receiver for a Display Controller

This block is the host-facing serial slave of a display controller. A frame opens when the active-low chip select falls. Each byte arrives least significant bit first, with data taken on the rising edge of the serial clock. The serial clock and data pins are oversampled against the fast system clock, and a pin level is accepted only after two consecutive sample ticks agree. Pulses shorter than one sample period therefore never reach the shifter.

The first byte of a frame is the command. A display-data command loads a start address, and every later byte in the same frame becomes a display RAM write at an address that advances by one and wraps. The block also marks the last byte of each per-digit group, which is 3 or 4 bytes long depending on a mode bit. Three other commands update the mode, timing-count and port registers. Any byte that follows one of them in the same frame is ignored.

A frame opened while `rd_arm` is high is a read-out frame. In such a frame the block shifts `rd_data` out on `sdo`, and `sdo_oe` controls the external tri-state buffer.

Top module: `disp_cmd_rx`

## Requirements
- R1: After reset: mode_q=0, tcnt_q=0, port_q=0, psel_q=2'b11, and ram_we, grp_end, byte_end and sdo_oe are all 0.
- R2: Bytes are assembled least significant bit first, one bit per rising edge of the filtered clock. The first complete byte of a frame is decoded as a command, using its top bits as the prefix.
- R3: A pulse on sclk or sdi shorter than one sample period (SMP_DIV system clocks) has no effect. A level is accepted only when two consecutive sample ticks see it.
- R4: While cs_n is high, clock and data edges are ignored and the bit counter is held at zero. A partial byte left when cs_n rises is discarded and produces no byte_end.
- R5: A command with prefix 3'b111 loads the start address from bits [4:0]. Each later byte in that frame gives one ram_we pulse with ram_addr and ram_wdata. The address then advances by one and wraps from 31 to 0.
- R6: A command with prefix 3'b110 loads mode_q from bits [4:0]. When mode_q[0]=1, display data is grouped in 3 bytes, and when it is 0, in 4 bytes. grp_end rises together with ram_we on the last byte of each group. The group count restarts at each display-data command.
- R7: A command with prefix 2'b10 loads tcnt_q from bits [3:0].
- R8: A command with bit 7 = 0 loads port_q from bits [2:0] and psel_q from bits [4:3].
- R9: Bytes that follow a mode, timing or port command within the same frame change no register and cause no ram_we.
- R10: byte_end is a one-cycle pulse for every completed byte. Register updates and RAM strobes for that byte are visible in the same cycle.
- R11: In a frame whose cs_n fall finds rd_arm high, sdo_oe stays high until cs_n rises. sdo shows rd_data[0] first and moves to the next bit after each filtered rising clock edge. No byte of that frame is decoded. sdo_oe is 0 whenever cs_n is high or the frame is not a read-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing a transfer |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial data from the host |
| rd_arm | input | 1 | Makes the next frame a read-out frame |
| rd_data | input | 8 | Byte shifted out in a read-out frame |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the data pin buffer |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 5 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| grp_end | output | 1 | Last byte of a per-digit data group |
| byte_end | output | 1 | One-cycle pulse per completed byte |
| mode_q | output | 5 | Display-state mode bits |
| tcnt_q | output | 4 | Timing-count setting |
| port_q | output | 3 | General output port data |
| psel_q | output | 2 | Digit/port switch selection |

## Verification
The bench builds the block with SMP_DIV=4, so a sample tick comes every four system clocks. Each serial bit can then be held for a few dozen cycles while two-sample agreement is still needed. With this setting, a one-cycle glitch on either pin falls well inside a single sample period and can be injected between real edges. The short tick period also lets full frames cover address wrap and both group lengths within a small cycle budget.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int MODE_W = 5;
  localparam int TCNT_W = 4;
  localparam int PORT_W = 3;
  localparam int PSEL_W = 2;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {FR_IDLE, FR_CMD, FR_DATA, FR_SKIP} frame_e;
  typedef enum logic [1:0] {CMD_DATA, CMD_MODE, CMD_TCNT, CMD_PORT} cmd_e;

  function automatic cmd_e cmd_of(input logic [BYTE_W-1:0] b);
    if (b[7:5] == 3'b111)      return CMD_DATA;
    else if (b[7:5] == 3'b110) return CMD_MODE;
    else if (b[7:6] == 2'b10)  return CMD_TCNT;
    else                       return CMD_PORT;
  endfunction
endpackage

// File: rtl/disp_rx_filt.sv
module disp_rx_filt #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_tick,
  input  logic pin,
  output logic lvl
);
  logic sync1_q, sync2_q, last_q, lvl_q;
  logic last_d, lvl_d;

  always_comb begin
    last_d = last_q;
    lvl_d  = lvl_q;
    if (smp_tick) begin
      last_d = sync2_q;
      if (sync2_q == last_q) lvl_d = sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= RST_VAL;
      sync2_q <= RST_VAL;
      last_q  <= RST_VAL;
      lvl_q   <= RST_VAL;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      last_q  <= last_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // R3
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_tick |=> $stable(lvl_q));
endmodule

// File: rtl/disp_rx_shift.sv
module disp_rx_shift
  import disp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_f,
  input  logic              sdi_f,
  input  logic              rd_arm,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              rd_mode,
  output logic              sdo
);
  logic              sclk_d_q, cs_d_q, vld_q, rd_q;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d, byte_r, byte_d, out_q, out_d;
  logic              vld_d, rd_d, rise, start;

  assign rise  = sclk_f & ~sclk_d_q & cs_act;
  assign start = cs_act & ~cs_d_q;

  always_comb begin
    bit_d  = bit_q;
    sh_d   = sh_q;
    byte_d = byte_r;
    vld_d  = 1'b0;
    rd_d   = rd_q;
    out_d  = out_q;
    if (!cs_act) begin
      bit_d = '0;
      rd_d  = 1'b0;
    end else if (rise) begin
      bit_d = bit_q + 1'b1;
      sh_d  = {sdi_f, sh_q[BYTE_W-1:1]};
      if (bit_q == BIT_W'(BYTE_W-1) && !rd_q) begin
        vld_d  = 1'b1;
        byte_d = {sdi_f, sh_q[BYTE_W-1:1]};
      end
      if (rd_q) out_d = out_q >> 1;
    end
    if (start) begin
      rd_d  = rd_arm;
      out_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b1;
      cs_d_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      byte_r   <= '0;
      vld_q    <= 1'b0;
      rd_q     <= 1'b0;
      out_q    <= '0;
    end else begin
      sclk_d_q <= sclk_f;
      cs_d_q   <= cs_act;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      byte_r   <= byte_d;
      vld_q    <= vld_d;
      rd_q     <= rd_d;
      out_q    <= out_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_q   = byte_r;
  assign rd_mode  = rd_q;
  assign sdo      = out_q[0];

  // R4
  bitcnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_q == '0);
  // R4
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(cs_act));
  // R11
  rd_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !vld_q);
endmodule

// File: rtl/disp_rx_dec.sv
module disp_rx_dec
  import disp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              grp_end,
  output logic              byte_end,
  output logic [MODE_W-1:0] mode_q,
  output logic [TCNT_W-1:0] tcnt_q,
  output logic [PORT_W-1:0] port_q,
  output logic [PSEL_W-1:0] psel_q
);
  frame_e            st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, waddr_q, waddr_d;
  logic [1:0]        grp_q, grp_d, grp_last;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d, ge_q, ge_d, be_q;
  logic [MODE_W-1:0] mode_r, mode_d;
  logic [TCNT_W-1:0] tcnt_r, tcnt_d;
  logic [PORT_W-1:0] port_r, port_d;
  logic [PSEL_W-1:0] psel_r, psel_d;

  assign grp_last = mode_r[0] ? 2'd2 : 2'd3;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    grp_d   = grp_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    ge_d    = 1'b0;
    mode_d  = mode_r;
    tcnt_d  = tcnt_r;
    port_d  = port_r;
    psel_d  = psel_r;
    if (st_q == FR_IDLE) st_d = FR_CMD;
    if (byte_vld) begin
      unique case (st_q)
        FR_CMD: begin
          st_d = FR_SKIP;
          unique case (cmd_of(byte_q))
            CMD_DATA: begin
              addr_d = byte_q[ADDR_W-1:0];
              grp_d  = '0;
              st_d   = FR_DATA;
            end
            CMD_MODE: mode_d = byte_q[MODE_W-1:0];
            CMD_TCNT: tcnt_d = byte_q[TCNT_W-1:0];
            CMD_PORT: begin
              port_d = byte_q[PORT_W-1:0];
              psel_d = byte_q[4:3];
            end
          endcase
        end
        FR_DATA: begin
          we_d    = 1'b1;
          waddr_d = addr_q;
          wdata_d = byte_q;
          addr_d  = addr_q + 1'b1;
          ge_d    = (grp_q == grp_last);
          grp_d   = ge_d ? 2'd0 : grp_q + 1'b1;
        end
        default: ;
      endcase
    end
    if (!cs_act) st_d = FR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FR_IDLE;
      addr_q  <= '0;
      grp_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      ge_q    <= 1'b0;
      be_q    <= 1'b0;
      mode_r  <= '0;
      tcnt_r  <= '0;
      port_r  <= '0;
      psel_r  <= '1;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      grp_q   <= grp_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      ge_q    <= ge_d;
      be_q    <= byte_vld;
      mode_r  <= mode_d;
      tcnt_r  <= tcnt_d;
      port_r  <= port_d;
      psel_r  <= psel_d;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = waddr_q;
  assign ram_wdata = wdata_q;
  assign grp_end   = ge_q;
  assign byte_end  = be_q;
  assign mode_q    = mode_r;
  assign tcnt_q    = tcnt_r;
  assign port_q    = port_r;
  assign psel_q    = psel_r;

  // R5
  we_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> be_q);
  // R10
  byte_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_q |=> !be_q);
  // R6
  grp_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ge_q |-> we_q);
  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && st_q == FR_SKIP) |=> (!we_q && $stable(mode_r) && $stable(tcnt_r)
                                       && $stable(port_r) && $stable(psel_r)));
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
  import disp_rx_pkg::*;
#(
  parameter int SMP_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              rd_arm,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              grp_end,
  output logic              byte_end,
  output logic [MODE_W-1:0] mode_q,
  output logic [TCNT_W-1:0] tcnt_q,
  output logic [PORT_W-1:0] port_q,
  output logic [PSEL_W-1:0] psel_q
);
  localparam int DIV_W  = (SMP_DIV > 2) ? $clog2(SMP_DIV) : 1;
  localparam int N_PINS = 2;

  logic [DIV_W-1:0]  div_q, div_d;
  logic              tick_q, tick_d;
  logic              cs_s1_q, cs_s2_q, cs_act;
  logic [N_PINS-1:0] raw_pins, flt_pins;
  logic              byte_vld, rd_mode;
  logic [BYTE_W-1:0] byte_q;

  always_comb begin
    tick_d = (div_q == DIV_W'(SMP_DIV-1));
    div_d  = tick_d ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      tick_q  <= 1'b0;
      cs_s1_q <= 1'b1;
      cs_s2_q <= 1'b1;
    end else begin
      div_q   <= div_d;
      tick_q  <= tick_d;
      cs_s1_q <= cs_n;
      cs_s2_q <= cs_s1_q;
    end
  end

  assign cs_act   = ~cs_s2_q;
  assign raw_pins = {sdi, sclk};

  for (genvar g = 0; g < N_PINS; g++) begin : g_filt
    disp_rx_filt #(.RST_VAL(1'b1)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_tick (tick_q),
      .pin      (raw_pins[g]),
      .lvl      (flt_pins[g])
    );
  end

  disp_rx_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sclk_f   (flt_pins[0]),
    .sdi_f    (flt_pins[1]),
    .rd_arm   (rd_arm),
    .rd_data  (rd_data),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .rd_mode  (rd_mode),
    .sdo      (sdo)
  );

  disp_rx_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .grp_end   (grp_end),
    .byte_end  (byte_end),
    .mode_q    (mode_q),
    .tcnt_q    (tcnt_q),
    .port_q    (port_q),
    .psel_q    (psel_q)
  );

  assign sdo_oe = ~cs_n & rd_mode;

  // R11
  oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !rd_mode);
endmodule

// File: tb/disp_cmd_rx_tb.sv
module disp_cmd_rx_tb;
  localparam int SMP  = 4;
  localparam int HOLD = 4 * SMP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b1, rd_arm = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sdo, sdo_oe, ram_we, grp_end, byte_end;
  logic [4:0] ram_addr, mode_q;
  logic [7:0] ram_wdata;
  logic [3:0] tcnt_q;
  logic [2:0] port_q;
  logic [1:0] psel_q;

  always #10 clk = ~clk;

  disp_cmd_rx #(.SMP_DIV(SMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .rd_arm(rd_arm), .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .grp_end(grp_end), .byte_end(byte_end), .mode_q(mode_q),
    .tcnt_q(tcnt_q), .port_q(port_q), .psel_q(psel_q)
  );

  typedef struct {
    logic we; logic [4:0] addr; logic [7:0] data; logic grp;
    logic [4:0] mode; logic [3:0] tcnt; logic [2:0] port; logic [1:0] psel;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_st;
  logic [4:0] m_addr, m_mode;
  logic [1:0] m_grp, m_psel;
  logic [3:0] m_tcnt;
  logic [2:0] m_port;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic model_byte(input logic [7:0] b, input string req);
    exp_t e;
    e.we = 0; e.addr = 0; e.data = b; e.grp = 0; e.req = req;
    if (m_st == 0) begin
      m_st = 2;
      if (b[7:5] == 3'b111) begin m_addr = b[4:0]; m_grp = 0; m_st = 1; end
      else if (b[7:5] == 3'b110) m_mode = b[4:0];
      else if (b[7:6] == 2'b10)  m_tcnt = b[3:0];
      else begin m_port = b[2:0]; m_psel = b[4:3]; end
    end else if (m_st == 1) begin
      e.we = 1; e.addr = m_addr;
      e.grp = (m_grp == (m_mode[0] ? 2'd2 : 2'd3));
      m_grp = e.grp ? 2'd0 : m_grp + 2'd1;
      m_addr = m_addr + 5'd1;
    end
    e.mode = m_mode; e.tcnt = m_tcnt; e.port = m_port; e.psel = m_psel;
    exp_q.push_back(e);
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit glitch);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = b[i];
      repeat (HOLD - 1) @(posedge clk);
      if (glitch) begin sdi = ~b[i]; @(posedge clk); sdi = b[i]; end
      else @(posedge clk);
      sclk = 1'b1;
      repeat (HOLD / 2) @(posedge clk);
      if (glitch) begin sclk = 1'b0; @(posedge clk); sclk = 1'b1; end
      repeat (HOLD / 2) @(posedge clk);
    end
  endtask

  task automatic frame(input logic [7:0] bytes [8], input int n, input bit glitch, input string req);
    m_st = 0;
    cs_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    for (int k = 0; k < n; k++) begin
      model_byte(bytes[k], req);
      drive_byte(bytes[k], glitch);
    end
    repeat (HOLD) @(posedge clk);
    cs_n = 1'b1;
    repeat (HOLD) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && byte_end) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected byte_end", 1, 0);
      end else begin
        exp_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = (ram_we == e.we) && (mode_q == e.mode) && (tcnt_q == e.tcnt)
             && (port_q == e.port) && (psel_q == e.psel);
        if (e.we) ok = ok && (ram_addr == e.addr) && (ram_wdata == e.data) && (grp_end == e.grp);
        check(ok, {e.req, " R10"},
              {ram_we, grp_end, ram_addr, ram_wdata, mode_q, tcnt_q, port_q, psel_q},
              {e.we, e.grp, e.addr, e.data, e.mode, e.tcnt, e.port, e.psel});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] fb [8];
    m_mode = 0; m_tcnt = 0; m_port = 0; m_psel = 2'b11; m_addr = 0; m_grp = 0; m_st = 0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check(mode_q == 0 && tcnt_q == 0 && port_q == 0 && psel_q == 2'b11, "R1 regs",
          {mode_q, tcnt_q, port_q, psel_q}, {5'd0, 4'd0, 3'd0, 2'b11});
    check(!ram_we && !grp_end && !byte_end && !sdo_oe, "R1 strobes",
          {ram_we, grp_end, byte_end, sdo_oe}, 0);

    // R6: 3-byte groups, R2 command decode
    fb[0] = 8'hC1;
    frame(fb, 1, 0, "R6 mode3");
    // R5 data from address 0, R6 grp_end on 3rd and 6th
    fb = '{8'hE0, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h00};
    frame(fb, 7, 0, "R5 R6 data3");
    // R6: 4-byte groups
    fb[0] = 8'hC0;
    frame(fb, 1, 0, "R6 mode4");
    // R5 wrap from 30
    fb = '{8'hFE, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h00, 8'h00};
    frame(fb, 6, 0, "R5 wrap R6 data4");
    // R7 timing count, R9 trailing bytes ignored
    fb = '{8'h85, 8'h12, 8'hC7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    frame(fb, 3, 0, "R7 R9 tcnt");
    // R8 port, R9 trailing data command ignored
    fb = '{8'h1D, 8'hE3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    frame(fb, 2, 0, "R8 R9 port");
    // R11 sdo_oe low in a normal frame
    cs_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    check(!sdo_oe, "R11 oe normal", sdo_oe, 0);
    // R4 partial byte discarded
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1;
      repeat (HOLD) @(posedge clk);
      sclk = 1'b1;
      repeat (HOLD) @(posedge clk);
    end
    cs_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    // R4 clock activity with cs_n high ignored
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = 1'b0;
      repeat (HOLD) @(posedge clk);
      sclk = 1'b1;
      repeat (HOLD) @(posedge clk);
    end
    fb[0] = 8'h8A;
    frame(fb, 1, 0, "R4 after partial");
    // R3 glitches on sclk and sdi
    fb = '{8'hE4, 8'h5A, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    frame(fb, 3, 1, "R3 glitch");
    // R11 read-out frame
    rd_arm = 1'b1; rd_data = 8'hA5;
    cs_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    rd_arm = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = 1'b1;
      repeat (HOLD) @(posedge clk);
      @(negedge clk);
      check(sdo_oe && sdo == rd_data[i], "R11 readout", {sdo_oe, sdo}, {1'b1, rd_data[i]});
      @(posedge clk);
      sclk = 1'b1;
      repeat (HOLD) @(posedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
    check(!sdo_oe, "R11 oe release", sdo_oe, 0);
    repeat (HOLD) @(posedge clk);
    // R11 no byte decoded in read-out; regs unchanged
    @(negedge clk);
    check(tcnt_q == m_tcnt && port_q == m_port && mode_q == m_mode, "R11 no decode",
          {mode_q, tcnt_q, port_q}, {m_mode, m_tcnt, m_port});
    check(exp_q.size() == 0, "R10 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule